// File: doc/BRIEF.md
# UART Register and Command Controller

This block is the host-side register front end of a byte-wide UART. A simple synchronous bus with a 6-bit address reaches a small set of byte registers: two mode bytes that share one address through a self-advancing pointer, a status byte, a command port, a data port that pops the receive queue on read and loads the transmit holding byte on write, an interrupt status/mask pair and two fixed baud bytes.

The command port takes a packed byte with three fields that all act in one write. A miscellaneous field resets the pointer, the receiver, the transmitter or the break flag. The other two fields enable or disable the transmitter and the receiver. The held transmit byte is passed to an external serializer through a valid/ready handshake. The receive FIFO lives outside this block: its empty and full flags are inputs here, and the block drives pop and flush strobes back to it. One level interrupt line is driven from the masked interrupt status.

Top module: `uart_regctl`

## Requirements
- R1: After a synchronous active-high reset the status byte reads 0x08, meaning only the transmit-empty flag is set. Both mode bytes, the interrupt mask, the break flag and both enables are zero. `tx_valid`, `irq` and `rx_en` are low.
- R2: The address is 6 bits, so offsets wrap every 0x40. A read with `bus_sel` high and `bus_we` low loads `bus_rdata` on that clock edge, and the value can be seen from the next cycle on. Offsets 0x18 and 0x1C read the parameters `BAUD1_VAL` and `BAUD2_VAL`. Offsets other than 0x00, 0x04, 0x0C, 0x14, 0x18 and 0x1C read 0x00. A write to 0x04 changes nothing.
- R3: Offset 0x00 reaches mode byte 0 or mode byte 1 through a 1-bit pointer. A write stores into the selected byte and then sets the pointer to 1. A read returns the selected byte. A command whose bits 6:4 equal 1 sets the pointer to 0.
- R4: A command write to 0x08 has three fields that act together: misc = bits 6:4, transmit = bits 3:2, receive = bits 1:0. In the transmit and receive fields, 1 enables, 2 disables, and 0 or 3 leave the enable unchanged. An enable or disable in these fields wins over a reset in the misc field of the same byte. `rx_en` shows the receiver enable.
- R5: Misc value 2 disables the receiver and pulses `rxf_flush` during the write cycle. Misc value 3 disables the transmitter, drops the held byte and sets transmit-empty. Misc value 5 clears the delta-break flag. Misc values 0, 4, 6 and 7 change nothing.
- R6: A write to 0x0C latches the byte into `tx_data` and clears transmit-empty. A further write before the byte is accepted replaces it. `tx_valid` is high while the transmitter is enabled and transmit-empty is clear. When `tx_valid` and `tx_ready` are both high at an edge, transmit-empty is set, unless a new byte is written at that same edge; in that case the new byte is held.
- R7: The status byte at 0x04 has these bits: bit0 = receive data ready (`!rxf_empty`), bit1 = FIFO full (`rxf_full`), bit2 = transmitter ready (equal to the transmitter enable), bit3 = transmit-empty. Bits 7:4 read 0.
- R8: A read of 0x0C while `rxf_empty` is low returns `rxf_data` and pulses `rxf_pop` for that one cycle. While `rxf_empty` is high the read returns 0x00 and gives no pop.
- R9: The interrupt status at 0x14 has these bits: bit0 = transmitter ready. Bit1 = FIFO full when bit 6 of mode byte 0 is 1, and receive data ready otherwise. Bit2 = delta break, which a `brk_event` pulse sets and misc value 5 clears. The other bits read 0.
- R10: A write to 0x14 loads the interrupt mask. `irq` is high exactly when the interrupt status AND the mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rxf_data | input | 8 | Head byte of the receive FIFO |
| rxf_empty | input | 1 | Receive FIFO empty |
| rxf_full | input | 1 | Receive FIFO full |
| rxf_pop | output | 1 | Pop strobe to the receive FIFO |
| rxf_flush | output | 1 | Flush strobe to the receive FIFO |
| rx_en | output | 1 | Receiver enable |
| brk_event | input | 1 | Break-change pulse from the receive side |
| tx_data | output | 8 | Held transmit byte |
| tx_valid | output | 1 | Held byte is offered to the serializer |
| tx_ready | input | 1 | Serializer accepts the byte |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a clash at one edge on the transmit side: the serializer accepts the held byte at the same edge that a new byte is written. If handled wrongly, the new byte is lost behind a stale empty flag. The stimulus first holds a byte with `tx_ready` low. It then raises `tx_ready` in the same cycle as a data-port write and checks that the new byte is still offered. Command bytes that combine a transmitter reset with an enable reach the other ordering case. Mode-byte writes that go around the pointer, with a pointer reset command between them, reach the case where the interrupt source is chosen.

// File: rtl/uart_regctl_pkg.sv
package uart_regctl_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] OFS_MODE  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CMD   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_INT   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_BAUD1 = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_BAUD2 = 6'h1C;

    localparam int MODE_RXSEL_BIT = 6;

    typedef enum logic [2:0] {
        MISC_NOP       = 3'd0,
        MISC_PTR_RST   = 3'd1,
        MISC_RX_RST    = 3'd2,
        MISC_TX_RST    = 3'd3,
        MISC_ERR_RST   = 3'd4,
        MISC_BRK_CLR   = 3'd5,
        MISC_BRK_START = 3'd6,
        MISC_BRK_STOP  = 3'd7
    } misc_e;

    typedef enum logic [1:0] {
        EN_KEEP = 2'd0,
        EN_ON   = 2'd1,
        EN_OFF  = 2'd2,
        EN_RSVD = 2'd3
    } en_cmd_e;

    typedef struct packed {
        misc_e   misc;
        en_cmd_e tx;
        en_cmd_e rx;
    } cmd_t;

    typedef struct packed {
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic brk_clr;
        logic tx_on;
        logic tx_off;
        logic rx_on;
        logic rx_off;
    } cmd_act_t;

    typedef struct packed {
        logic [3:0] zero;
        logic       tx_empty;
        logic       tx_rdy;
        logic       rx_full;
        logic       rx_rdy;
    } status_t;

    typedef struct packed {
        logic [4:0] zero;
        logic       brk;
        logic       rx;
        logic       tx;
    } int_stat_t;

    function automatic cmd_act_t decode_cmd(input logic strobe, input cmd_t c);
        cmd_act_t a;
        a = '0;
        if (strobe) begin
            a.ptr_rst = (c.misc == MISC_PTR_RST);
            a.rx_rst  = (c.misc == MISC_RX_RST);
            a.tx_rst  = (c.misc == MISC_TX_RST);
            a.brk_clr = (c.misc == MISC_BRK_CLR);
            a.tx_on   = (c.tx == EN_ON);
            a.tx_off  = (c.tx == EN_OFF);
            a.rx_on   = (c.rx == EN_ON);
            a.rx_off  = (c.rx == EN_OFF);
        end
        return a;
    endfunction

    // Later fields override earlier ones: enable/disable beats a misc reset.
    function automatic logic next_enable(input logic cur, input logic reset_f,
                                         input logic on_f, input logic off_f);
        logic n;
        n = reset_f ? 1'b0 : cur;
        if (on_f)
            n = 1'b1;
        else if (off_f)
            n = 1'b0;
        return n;
    endfunction

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
    import uart_regctl_pkg::*;
(
    input  logic            cmd_wr,
    input  logic [6:0]      cmd_byte,
    output cmd_act_t        act
);
    cmd_t cmd_w;

    always_comb begin
        cmd_w = cmd_t'(cmd_byte);
        act   = decode_cmd(cmd_wr, cmd_w);
    end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_regctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_act_t          act,
    input  logic              hold_wr,
    input  logic [DATA_W-1:0] hold_byte,
    input  logic              tx_ready,
    output logic              tx_en,
    output logic              tx_empty,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data
);
    logic              en_q;
    logic              empty_q;
    logic [DATA_W-1:0] byte_q;
    logic              accept;

    assign tx_valid = en_q && !empty_q;
    assign accept   = tx_valid && tx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            empty_q <= 1'b1;
            byte_q  <= '0;
        end else begin
            en_q <= next_enable(en_q, act.tx_rst, act.tx_on, act.tx_off);
            if (hold_wr) begin
                byte_q  <= hold_byte;
                empty_q <= 1'b0;
            end else if (act.tx_rst || accept) begin
                empty_q <= 1'b1;
            end
        end
    end

    assign tx_en    = en_q;
    assign tx_empty = empty_q;
    assign tx_data  = byte_q;
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
    import uart_regctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_rdy,
    input  logic              rx_rdy,
    input  logic              rx_full,
    input  logic              rx_sel_full,
    input  logic              brk_event,
    input  logic              brk_clr,
    input  logic              mask_wr,
    input  logic [DATA_W-1:0] mask_byte,
    output int_stat_t         int_stat,
    output logic [DATA_W-1:0] int_mask,
    output logic              irq
);
    logic              brk_q;
    logic [DATA_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_q  <= 1'b0;
            mask_q <= '0;
        end else begin
            if (brk_event)
                brk_q <= 1'b1;
            else if (brk_clr)
                brk_q <= 1'b0;
            if (mask_wr)
                mask_q <= mask_byte;
        end
    end

    always_comb begin
        int_stat      = '0;
        int_stat.tx   = tx_rdy;
        int_stat.rx   = rx_sel_full ? rx_full : rx_rdy;
        int_stat.brk  = brk_q;
    end

    assign int_mask = mask_q;
    assign irq      = |(int_stat & mask_q);
endmodule

// File: rtl/uart_regctl.sv
module uart_regctl
    import uart_regctl_pkg::*;
#(
    parameter logic [7:0] BAUD1_VAL = 8'h00,
    parameter logic [7:0] BAUD2_VAL = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [5:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  rxf_data,
    input  logic        rxf_empty,
    input  logic        rxf_full,
    output logic        rxf_pop,
    output logic        rxf_flush,
    output logic        rx_en,
    input  logic        brk_event,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic        irq
);
    localparam int NUM_MODE = 2;

    logic wr_stb, rd_stb;
    logic cmd_wr, hold_wr, mask_wr, mode_wr;
    cmd_act_t act;

    logic [DATA_W-1:0] mode_q [NUM_MODE];
    logic              mode_ptr;
    logic              rx_en_q;
    logic              tx_en_w, tx_empty_w;
    status_t           stat_w;
    int_stat_t         int_stat_w;
    logic [DATA_W-1:0] int_mask_w;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_q;

    assign wr_stb  = bus_sel && bus_we;
    assign rd_stb  = bus_sel && !bus_we;
    assign cmd_wr  = wr_stb && (bus_addr == OFS_CMD);
    assign hold_wr = wr_stb && (bus_addr == OFS_DATA);
    assign mask_wr = wr_stb && (bus_addr == OFS_INT);
    assign mode_wr = wr_stb && (bus_addr == OFS_MODE);

    uart_cmd_decode u_dec (
        .cmd_wr   (cmd_wr),
        .cmd_byte (bus_wdata[6:0]),
        .act      (act)
    );

    uart_tx_hold u_tx (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .hold_wr   (hold_wr),
        .hold_byte (bus_wdata),
        .tx_ready  (tx_ready),
        .tx_en     (tx_en_w),
        .tx_empty  (tx_empty_w),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    uart_irq_unit u_irq (
        .clk         (clk),
        .rst         (rst),
        .tx_rdy      (tx_en_w),
        .rx_rdy      (!rxf_empty),
        .rx_full     (rxf_full),
        .rx_sel_full (mode_q[0][MODE_RXSEL_BIT]),
        .brk_event   (brk_event),
        .brk_clr     (act.brk_clr),
        .mask_wr     (mask_wr),
        .mask_byte   (bus_wdata),
        .int_stat    (int_stat_w),
        .int_mask    (int_mask_w),
        .irq         (irq)
    );

    // Mode bytes behind the self-advancing pointer.
    generate
        for (genvar gi = 0; gi < NUM_MODE; gi++) begin : g_mode
            always_ff @(posedge clk) begin
                if (rst)
                    mode_q[gi] <= '0;
                else if (mode_wr && (int'(mode_ptr) == gi))
                    mode_q[gi] <= bus_wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_ptr <= 1'b0;
            rx_en_q  <= 1'b0;
        end else begin
            if (mode_wr)
                mode_ptr <= 1'b1;
            else if (act.ptr_rst)
                mode_ptr <= 1'b0;
            rx_en_q <= next_enable(rx_en_q, act.rx_rst, act.rx_on, act.rx_off);
        end
    end

    always_comb begin
        stat_w          = '0;
        stat_w.rx_rdy   = !rxf_empty;
        stat_w.rx_full  = rxf_full;
        stat_w.tx_rdy   = tx_en_w;
        stat_w.tx_empty = tx_empty_w;
    end

    always_comb begin
        case (bus_addr)
            OFS_MODE:  rd_val = mode_q[mode_ptr];
            OFS_STAT:  rd_val = stat_w;
            OFS_DATA:  rd_val = rxf_empty ? '0 : rxf_data;
            OFS_INT:   rd_val = int_stat_w;
            OFS_BAUD1: rd_val = BAUD1_VAL;
            OFS_BAUD2: rd_val = BAUD2_VAL;
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd_stb)
            rdata_q <= rd_val;
    end

    assign bus_rdata = rdata_q;
    assign rxf_pop   = rd_stb && (bus_addr == OFS_DATA) && !rxf_empty;
    assign rxf_flush = act.rx_rst;
    assign rx_en     = rx_en_q;

    logic unused_mask;
    assign unused_mask = ^int_mask_w;
endmodule

// File: rtl/uart_regctl_chk.sv
module uart_regctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_sel,
    input logic       bus_we,
    input logic [5:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       rxf_empty,
    input logic       rxf_pop,
    input logic       rxf_flush,
    input logic       rx_en,
    input logic       brk_event,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       irq,
    input logic [7:0] int_stat
);
    logic tx_wr, cmd_wr;
    assign tx_wr  = bus_sel && bus_we && (bus_addr == 6'h0C);
    assign cmd_wr = bus_sel && bus_we && (bus_addr == 6'h08);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tx_valid && !irq && !rx_en));

    p_pop_qualified_r8: assert property (@(posedge clk) disable iff (rst)
        rxf_pop |-> (bus_sel && !bus_we && bus_addr == 6'h0C && !rxf_empty));

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !tx_wr && !cmd_wr) |=> (tx_valid && $stable(tx_data)));

    p_accept_empties_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && !tx_wr && !cmd_wr) |=> !tx_valid);

    p_flush_disables_r5: assert property (@(posedge clk) disable iff (rst)
        (rxf_flush && bus_wdata[1:0] != 2'd1) |=> !rx_en);

    p_brk_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && bus_wdata[6:4] == 3'd5 && !brk_event) |=> !int_stat[2]);

    p_rx_enable_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && bus_wdata[1:0] == 2'd1) |=> rx_en);
endmodule

bind uart_regctl uart_regctl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rxf_empty (rxf_empty),
    .rxf_pop   (rxf_pop),
    .rxf_flush (rxf_flush),
    .rx_en     (rx_en),
    .brk_event (brk_event),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .irq       (irq),
    .int_stat  (int_stat_w)
);

// File: tb/tb_uart_regctl.sv
`timescale 1ns/1ps
module tb_uart_regctl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] rxf_data = '0;
    logic       rxf_empty = 1'b1, rxf_full = 1'b0;
    logic       rxf_pop, rxf_flush, rx_en;
    logic       brk_event = 1'b0;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic       irq;

    int n_chk = 0, n_fail = 0;
    logic pop_seen, flush_seen;
    logic [7:0] rd;

    always #2.5 clk = ~clk;

    uart_regctl #(.BAUD1_VAL(8'h5A), .BAUD2_VAL(8'hC4)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxf_data(rxf_data), .rxf_empty(rxf_empty), .rxf_full(rxf_full),
        .rxf_pop(rxf_pop), .rxf_flush(rxf_flush), .rx_en(rx_en),
        .brk_event(brk_event), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rxf_empty = 1'b1; rxf_full = 1'b0; tx_ready = 1'b0;
        @(posedge clk); #1 rst = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        #1 flush_seen = rxf_flush;
        @(posedge clk); #1 bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rdr(input logic [5:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 pop_seen = rxf_pop;
        @(posedge clk); #1 bus_sel = 1'b0;
        v = bus_rdata;
    endtask

    task automatic t_reset_map();
        do_reset();
        rdr(6'h04, rd); chk("R1 status after reset", rd, 8'h08);
        rdr(6'h00, rd); chk("R1 mode0 after reset", rd, 8'h00);
        rdr(6'h14, rd); chk("R1 int status after reset", rd, 8'h00);
        chk("R1 outputs after reset", {5'b0, tx_valid, irq, rx_en}, 8'h00);
        wr(6'h04, 8'hFF);
        rdr(6'h04, rd); chk("R2 status write ignored", rd, 8'h08);
        rdr(6'h18, rd); chk("R2 baud byte 1", rd, 8'h5A);
        rdr(6'h1C, rd); chk("R2 baud byte 2", rd, 8'hC4);
        rdr(6'h10, rd); chk("R2 unused 0x10", rd, 8'h00);
        rdr(6'h08, rd); chk("R2 command reads zero", rd, 8'h00);
        rdr(6'h3C, rd); chk("R2 unused 0x3C", rd, 8'h00);
    endtask

    task automatic t_mode();
        do_reset();
        wr(6'h00, 8'hA5);
        wr(6'h00, 8'h3C);
        rdr(6'h00, rd); chk("R3 pointer advanced to mode1", rd, 8'h3C);
        wr(6'h00, 8'hC3);
        rdr(6'h00, rd); chk("R3 pointer stays at mode1", rd, 8'hC3);
        wr(6'h08, 8'h10);
        rdr(6'h00, rd); chk("R3 pointer reset to mode0", rd, 8'hA5);
        wr(6'h00, 8'h11);
        rdr(6'h00, rd); chk("R3 mode1 kept after mode0 write", rd, 8'hC3);
        wr(6'h08, 8'h10);
        rdr(6'h00, rd); chk("R3 mode0 rewritten", rd, 8'h11);
    endtask

    task automatic t_tx();
        do_reset();
        wr(6'h08, 8'h04);
        rdr(6'h04, rd); chk("R7 tx enabled status", rd, 8'h0C);
        chk("R6 no byte offered", {7'b0, tx_valid}, 8'h00);
        wr(6'h0C, 8'h55);
        chk("R6 byte offered", {7'b0, tx_valid}, 8'h01);
        chk("R6 tx data", tx_data, 8'h55);
        rdr(6'h04, rd); chk("R7 empty cleared", rd, 8'h04);
        wr(6'h0C, 8'h66);
        chk("R6 overwrite held byte", tx_data, 8'h66);
        @(negedge clk); tx_ready = 1'b1;
        @(posedge clk); #1 tx_ready = 1'b0;
        chk("R6 accept drops valid", {7'b0, tx_valid}, 8'h00);
        rdr(6'h04, rd); chk("R6 empty after accept", rd, 8'h0C);
        wr(6'h08, 8'h08);
        rdr(6'h04, rd); chk("R4 tx disable", rd, 8'h08);
        wr(6'h0C, 8'h77);
        chk("R6 no offer while disabled", {7'b0, tx_valid}, 8'h00);
        rdr(6'h04, rd); chk("R7 held while disabled", rd, 8'h00);
        wr(6'h08, 8'h04);
        chk("R6 offered on re-enable", {tx_valid, tx_data[6:0]}, 8'hF7);
        wr(6'h08, 8'h34);
        rdr(6'h04, rd); chk("R5 tx reset then enable", rd, 8'h0C);
        chk("R5 held byte dropped", {7'b0, tx_valid}, 8'h00);
        wr(6'h08, 8'h0C);
        rdr(6'h04, rd); chk("R4 reserved tx field", rd, 8'h0C);
        wr(6'h0C, 8'h11);
        @(negedge clk);
        tx_ready = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'h0C; bus_wdata = 8'h22;
        @(posedge clk); #1 tx_ready = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        chk("R6 write wins over accept", {tx_valid, tx_data[6:0]}, 8'hA2);
        wr(6'h08, 8'h30);
        rdr(6'h04, rd); chk("R5 tx reset alone", rd, 8'h08);
    endtask

    task automatic t_rx();
        do_reset();
        wr(6'h08, 8'h01); chk("R4 rx enable", {7'b0, rx_en}, 8'h01);
        wr(6'h08, 8'h03); chk("R4 reserved rx field", {7'b0, rx_en}, 8'h01);
        wr(6'h08, 8'h02); chk("R4 rx disable", {7'b0, rx_en}, 8'h00);
        wr(6'h08, 8'h21);
        chk("R5 flush pulse", {7'b0, flush_seen}, 8'h01);
        chk("R4 enable beats rx reset", {7'b0, rx_en}, 8'h01);
        wr(6'h08, 8'h20);
        chk("R5 rx reset disables", {7'b0, rx_en}, 8'h00);
        wr(6'h08, 8'h00);
        chk("R5 misc 0 no flush", {7'b0, flush_seen}, 8'h00);
        rxf_empty = 1'b0; rxf_full = 1'b1; rxf_data = 8'h9A;
        rdr(6'h04, rd); chk("R7 rx flags in status", rd, 8'h0B);
        chk("R8 status read no pop", {7'b0, pop_seen}, 8'h00);
        rdr(6'h0C, rd);
        chk("R8 pop on data read", {7'b0, pop_seen}, 8'h01);
        chk("R8 data returned", rd, 8'h9A);
        rxf_empty = 1'b1; rxf_full = 1'b0;
        rdr(6'h0C, rd);
        chk("R8 empty read no pop", {7'b0, pop_seen}, 8'h00);
        chk("R8 empty read zero", rd, 8'h00);
    endtask

    task automatic t_irq();
        do_reset();
        wr(6'h14, 8'h07);
        chk("R10 quiet with sources low", {7'b0, irq}, 8'h00);
        rxf_empty = 1'b0;
        rdr(6'h14, rd); chk("R9 rx source = data ready", rd, 8'h02);
        chk("R10 irq from rx", {7'b0, irq}, 8'h01);
        wr(6'h00, 8'h40);
        rdr(6'h14, rd); chk("R9 rx source = full, not full", rd, 8'h00);
        chk("R10 irq drops", {7'b0, irq}, 8'h00);
        rxf_full = 1'b1;
        rdr(6'h14, rd); chk("R9 full source set", rd, 8'h02);
        @(negedge clk); brk_event = 1'b1;
        @(posedge clk); #1 brk_event = 1'b0;
        rdr(6'h14, rd); chk("R9 delta break set", rd, 8'h06);
        wr(6'h14, 8'h04);
        chk("R10 irq from break", {7'b0, irq}, 8'h01);
        wr(6'h08, 8'h40); wr(6'h08, 8'h60); wr(6'h08, 8'h70);
        rdr(6'h14, rd); chk("R5 misc 4/6/7 no effect", rd, 8'h06);
        wr(6'h08, 8'h50);
        rdr(6'h14, rd); chk("R5 break cleared", rd, 8'h02);
        chk("R10 irq off after clear", {7'b0, irq}, 8'h00);
        wr(6'h08, 8'h04);
        rdr(6'h14, rd); chk("R9 tx ready bit", rd, 8'h03);
        wr(6'h14, 8'h01);
        chk("R10 irq from tx", {7'b0, irq}, 8'h01);
        wr(6'h14, 8'h00);
        chk("R10 mask zero", {7'b0, irq}, 8'h00);
        rxf_empty = 1'b1; rxf_full = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_map();
        t_mode();
        t_tx();
        t_rx();
        t_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule